// File: doc/BRIEF.md
# Serial Flash Status Register and Write Guard

This block is the command front end of a serial flash slave that owns the status register and decides whether writes may happen. It watches the serial pins (chip select, serial clock and serial data in) together with an active-low write-protect pin. It decodes four one-byte commands: set the write-enable latch, clear the latch, read status and write status. It returns the status byte on serial data out.

The serial pins are brought into the block's own clock domain through synchronizers, and clock edges are found by comparing successive samples. Both serial clock modes (0 and 3) work, and input data is always taken on the rising serial clock edge.

A second, parallel output tells the rest of the flash whether a program or erase aimed at a given address may go ahead. That decision combines the write-enable latch, the busy flag and the region covered by the block-protect code. A status write is refused while the write-disable bit is set and the protect pin is low. The pin level is the one present when chip select rises.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset the status byte reads 00h while `busy_in` is low: the write-enable latch, the block-protect code and the write-disable bit are all 0.
- R2: A transfer of exactly the byte 06h sets the write-enable latch (status bit 1). A transfer of exactly 04h clears it. The latch changes only in the cycle after chip select rises.
- R3: After the byte 05h, every following byte shifts out the live status value, MSB first, for as long as chip select stays low. The status layout is: bit 0 busy (follows `busy_in`), bit 1 write-enable latch, bits 4:2 block-protect code, bits 6:5 always 0, bit 7 write-disable.
- R4: A transfer of exactly two bytes, 01h followed by a data byte, is accepted when the latch is set and either the write-disable bit is 0 or `wp_n` is high. An accepted write loads data bits 7 and 4:2 and ignores all other data bits.
- R5: A write-status transfer made while the latch is clear changes nothing.
- R6: While the write-disable bit is 1 and `wp_n` is low, every write-status transfer is refused even when the latch is set. This holds whichever of the two conditions arose first. Raising `wp_n` makes writes possible again.
- R7: Every complete write-status transfer, accepted or refused, clears the latch.
- R8: A transfer has no effect if chip select rises partway through a byte, or if the transfer carries a byte count other than the command's own.
- R9: Serial clock mode 0 (idle low) and mode 3 (idle high) both work.
- R10: For block-protect code c from 1 to 6, the protected region is every address at or above 2^17 − 2^17/2^(7−c). Code 7 protects every address, and code 0 protects none.
- R11: `addr_writable` is 1 only when the latch is set, busy is low and `chk_addr` lies outside the protected region.
- R12: `spi_miso` stays 0 except while a read-status transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Write-protect pin, active low |
| busy_in | input | 1 | Busy indication from the array sequencer (stub) |
| chk_addr | input | 17 | Address whose program/erase permission is queried |
| spi_miso | output | 1 | Serial data out |
| addr_writable | output | 1 | 1 when a program or erase at `chk_addr` may proceed |

## Verification
The hardest state to reach is hardware-protected mode. It can only be entered through a sequence of complete serial transfers: set the latch, write a status byte with bit 7 set, then lower `wp_n`. The other route lowers the pin first and then sets bit 7. The bench drives both orders. In each it sets the latch again and attempts a status write that should be refused. It then reads status back over the serial port to confirm that the register is unchanged and the latch has been cleared. Finally it raises the pin and repeats the write, which must now be accepted.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    localparam int BYTE_W     = 8;
    localparam int BP_W       = 3;
    localparam int ARR_ADDR_W = 17;

    localparam logic [BYTE_W-1:0] OPC_STATUS_WR = 8'h01;
    localparam logic [BYTE_W-1:0] OPC_LATCH_CLR = 8'h04;
    localparam logic [BYTE_W-1:0] OPC_STATUS_RD = 8'h05;
    localparam logic [BYTE_W-1:0] OPC_LATCH_SET = 8'h06;

    typedef struct packed {
        logic            wr_lock;   // bit 7
        logic [1:0]      spare;     // bits 6:5, read as zero
        logic [BP_W-1:0] guard;     // bits 4:2
        logic            wel;       // bit 1
        logic            busy;      // bit 0
    } status_t;

    typedef enum logic [2:0] {
        CMD_OPCODE,
        CMD_SET,
        CMD_CLR,
        CMD_READ,
        CMD_WR_WAIT,
        CMD_WR_HAVE,
        CMD_DISCARD
    } cmd_state_e;

    function automatic logic wr_blocked(input logic lock, input logic pin_n);
        return lock & ~pin_n;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic csn,
    input  logic sck,
    input  logic mosi,
    input  logic wp_n,
    output logic csn_s,
    output logic mosi_s,
    output logic wp_n_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_end
);
    localparam int NPIN = 4;
    localparam logic [NPIN-1:0] IDLE = 4'b1001;  // {csn, sck, mosi, wp_n}

    logic [NPIN-1:0] pipe [STAGES];
    logic            sck_d;
    logic            csn_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= IDLE;
            sck_d <= 1'b0;
            csn_d <= 1'b1;
        end else begin
            pipe[0] <= {csn, sck, mosi, wp_n};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            sck_d <= pipe[STAGES-1][2];
            csn_d <= pipe[STAGES-1][3];
        end
    end

    assign csn_s    = pipe[STAGES-1][3];
    assign mosi_s   = pipe[STAGES-1][1];
    assign wp_n_s   = pipe[STAGES-1][0];
    assign sck_rise = pipe[STAGES-1][2] & ~sck_d;
    assign sck_fall = ~pipe[STAGES-1][2] & sck_d;
    assign cs_end   = pipe[STAGES-1][3] & ~csn_d;

endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_s,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] tx_data,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              cs_aligned,
    output logic              tx_bit
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            tx_sh    <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (csn_s) begin
                bit_cnt <= '0;
            end else begin
                if (sck_rise) begin
                    rx_sh <= {rx_sh[BYTE_W-3:0], mosi_s};
                    if (bit_cnt == LAST) begin
                        bit_cnt  <= '0;
                        rx_byte  <= {rx_sh, mosi_s};
                        rx_valid <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                // Output changes on the falling edge; a byte boundary reloads.
                if (sck_fall) begin
                    if (bit_cnt == '0) tx_sh <= tx_data;
                    else               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign cs_aligned = (bit_cnt == '0);
    assign tx_bit     = tx_sh[BYTE_W-1];

endmodule

// File: rtl/sr_cmd_ctrl.sv
module sr_cmd_ctrl
    import flash_sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              cs_end,
    input  logic              cs_aligned,
    input  logic              wp_n_s,
    input  logic              busy_in,
    output status_t           status,
    output logic              read_active
);
    cmd_state_e      state;
    logic            lock_q;
    logic [BP_W-1:0] guard_q;
    logic            wel_q;
    logic            new_lock;
    logic [BP_W-1:0] new_guard;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CMD_OPCODE;
            lock_q    <= 1'b0;
            guard_q   <= '0;
            wel_q     <= 1'b0;
            new_lock  <= 1'b0;
            new_guard <= '0;
        end else if (cs_end) begin
            state <= CMD_OPCODE;
            if (cs_aligned) begin
                unique case (state)
                    CMD_SET: wel_q <= 1'b1;
                    CMD_CLR: wel_q <= 1'b0;
                    CMD_WR_HAVE: begin
                        if (wel_q && !wr_blocked(lock_q, wp_n_s)) begin
                            lock_q  <= new_lock;
                            guard_q <= new_guard;
                        end
                        wel_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end else if (rx_valid) begin
            unique case (state)
                CMD_OPCODE: begin
                    unique case (rx_byte)
                        OPC_LATCH_SET: state <= CMD_SET;
                        OPC_LATCH_CLR: state <= CMD_CLR;
                        OPC_STATUS_RD: state <= CMD_READ;
                        OPC_STATUS_WR: state <= CMD_WR_WAIT;
                        default:       state <= CMD_DISCARD;
                    endcase
                end
                CMD_WR_WAIT: begin
                    new_lock  <= rx_byte[BYTE_W-1];
                    new_guard <= rx_byte[BP_W+1:2];
                    state     <= CMD_WR_HAVE;
                end
                CMD_READ:    state <= CMD_READ;
                default:     state <= CMD_DISCARD;
            endcase
        end
    end

    always_comb begin
        status.wr_lock = lock_q;
        status.spare   = 2'b00;
        status.guard   = guard_q;
        status.wel     = wel_q;
        status.busy    = busy_in;
    end

    assign read_active = (state == CMD_READ);

endmodule

// File: rtl/region_guard.sv
module region_guard #(
    parameter int AW   = 17,
    parameter int BP_W = 3
) (
    input  logic [AW-1:0]   addr,
    input  logic [BP_W-1:0] code,
    output logic            protected_o
);
    localparam int NCODE = 1 << BP_W;

    logic [NCODE-1:0] hit;

    assign hit[0] = 1'b0;

    // Code c guards the top 1/2^(NCODE-1-c) of the space; the last code guards all.
    for (genvar c = 1; c < NCODE; c++) begin : g_code
        localparam int SHIFT = NCODE - 1 - c;
        if (SHIFT == 0) begin : g_all
            assign hit[c] = 1'b1;
        end else begin : g_top
            assign hit[c] = &addr[AW-1 -: SHIFT];
        end
    end

    assign protected_o = hit[code];

endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
    import flash_sr_pkg::*;
#(
    parameter int ADDR_W      = ARR_ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_csn,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              wp_n,
    input  logic              busy_in,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              spi_miso,
    output logic              addr_writable
);
    logic              csn_s, mosi_s, wp_n_s, sck_rise, sck_fall, cs_end;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_valid, cs_aligned, tx_bit, read_active, in_region;
    status_t           sr;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .csn(spi_csn), .sck(spi_sck), .mosi(spi_mosi),
        .wp_n(wp_n), .csn_s(csn_s), .mosi_s(mosi_s), .wp_n_s(wp_n_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_end(cs_end)
    );

    spi_byte_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst(rst), .csn_s(csn_s), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .mosi_s(mosi_s), .tx_data(sr),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .cs_aligned(cs_aligned),
        .tx_bit(tx_bit)
    );

    sr_cmd_ctrl u_ctrl (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .cs_end(cs_end), .cs_aligned(cs_aligned), .wp_n_s(wp_n_s),
        .busy_in(busy_in), .status(sr), .read_active(read_active)
    );

    region_guard #(.AW(ADDR_W), .BP_W(BP_W)) u_region (
        .addr(chk_addr), .code(sr.guard), .protected_o(in_region)
    );

    assign spi_miso      = read_active & tx_bit;
    assign addr_writable = sr.wel & ~sr.busy & ~in_region;

endmodule

// File: rtl/flash_sr_guard_chk.sv
module flash_sr_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       csn_s,
    input logic       wp_n_s,
    input logic       cs_end,
    input logic [7:0] sr_bits,
    input logic       spi_miso,
    input logic       addr_writable
);
    // R6: locked register with the pin low keeps its writable fields.
    assert_hpm_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (sr_bits[7] && !wp_n_s) |=> $stable({sr_bits[7], sr_bits[4:2]}));

    // R5: nothing is written while the latch is clear.
    assert_no_write_without_wel_R5: assert property (@(posedge clk) disable iff (rst)
        !sr_bits[1] |=> $stable({sr_bits[7], sr_bits[4:2]}));

    // R2: the latch moves only right after chip select rises.
    assert_wel_moves_at_cs_end_R2: assert property (@(posedge clk) disable iff (rst)
        !cs_end |=> $stable(sr_bits[1]));

    // R11: permission needs the latch and an idle array.
    assert_writable_gated_R11: assert property (@(posedge clk) disable iff (rst)
        addr_writable |-> (sr_bits[1] && !sr_bits[0]));

    // R12: data out rests low between transfers.
    assert_miso_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (csn_s && $past(csn_s)) |-> !spi_miso);

endmodule

bind flash_sr_guard flash_sr_guard_chk u_chk (
    .clk(clk), .rst(rst), .csn_s(csn_s), .wp_n_s(wp_n_s), .cs_end(cs_end),
    .sr_bits(sr), .spi_miso(spi_miso), .addr_writable(addr_writable)
);

// File: tb/flash_sr_guard_tb.sv
module flash_sr_guard_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_csn = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        wp_n = 1'b1;
    logic        busy_in = 1'b0;
    logic [16:0] chk_addr = '0;
    logic        spi_miso;
    logic        addr_writable;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    logic m3 = 1'b0;

    always #4 clk = ~clk;

    flash_sr_guard u_dut (
        .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .wp_n(wp_n), .busy_in(busy_in),
        .chk_addr(chk_addr), .spi_miso(spi_miso), .addr_writable(addr_writable)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic spi_txn(input logic [23:0] data, input int nbits,
                           output logic [7:0] rx);
        rx = '0;
        spi_sck = m3;
        wait_clks(4);
        spi_csn = 1'b0;
        wait_clks(6);
        for (int i = 0; i < nbits; i++) begin
            spi_sck  = 1'b0;
            spi_mosi = data[23-i];
            wait_clks(6);
            rx = {rx[6:0], spi_miso};
            spi_sck = 1'b1;
            wait_clks(6);
        end
        spi_sck = m3;
        wait_clks(6);
        spi_csn = 1'b1;
        wait_clks(8);
    endtask

    task automatic cmd_set();
        logic [7:0] r;
        spi_txn({8'h06, 16'h0}, 8, r);
    endtask

    task automatic cmd_clr();
        logic [7:0] r;
        spi_txn({8'h04, 16'h0}, 8, r);
    endtask

    task automatic cmd_wr(input logic [7:0] v);
        logic [7:0] r;
        spi_txn({8'h01, v, 8'h0}, 16, r);
    endtask

    task automatic cmd_rd(output logic [7:0] v);
        spi_txn({8'h05, 16'h0}, 16, v);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R1", "writable after reset", 32'(addr_writable), 0);
        cmd_rd(s);
        chk("R1", "status after reset", 32'(s), 32'h00);
    endtask

    task automatic t_latch();
        logic [7:0] s;
        cmd_set();
        cmd_rd(s);
        chk("R2", "status after 06h", 32'(s), 32'h02);
        chk_addr = 17'h0;
        wait_clks(2);
        chk("R11", "writable with latch, code 0", 32'(addr_writable), 1);
        cmd_clr();
        cmd_rd(s);
        chk("R2", "status after 04h", 32'(s), 32'h00);
    endtask

    task automatic t_no_latch();
        logic [7:0] s;
        cmd_wr(8'h9C);
        cmd_rd(s);
        chk("R5", "write without latch", 32'(s), 32'h00);
    endtask

    task automatic t_write();
        logic [7:0] s;
        cmd_set();
        cmd_wr(8'h6F);  // only bits 7 and 4:2 land: expect 0Ch
        cmd_rd(s);
        chk("R4", "masked write, latch cleared", 32'(s), 32'h0C);
        chk("R7", "latch bit after accepted write", 32'(s[1]), 0);
        cmd_set();
        cmd_wr(8'h00);
        cmd_rd(s);
        chk("R4", "write back to zero", 32'(s), 32'h00);
    endtask

    task automatic t_regions();
        logic [7:0] s;
        for (int c = 0; c < 8; c++) begin
            cmd_set();
            cmd_wr(8'(c << 2));
            cmd_set();
            cmd_rd(s);
            chk("R10", "code readback", 32'(s), 32'(8'(c << 2) | 8'h02));
            if (c == 0) begin
                chk_addr = 17'h1FFFF;
                wait_clks(2);
                chk("R10", "code 0 top address", 32'(addr_writable), 1);
            end else if (c == 7) begin
                chk_addr = 17'h0;
                wait_clks(2);
                chk("R10", "code 7 address 0", 32'(addr_writable), 0);
            end else begin
                int floor_a;
                floor_a = 131072 - (1 << (17 - (7 - c)));
                chk_addr = 17'(floor_a - 1);
                wait_clks(2);
                chk("R10", "just below floor", 32'(addr_writable), 1);
                chk_addr = 17'(floor_a);
                wait_clks(2);
                chk("R10", "at floor", 32'(addr_writable), 0);
            end
        end
        cmd_set();
        cmd_wr(8'h00);
    endtask

    task automatic t_hpm_lock_first();
        logic [7:0] s;
        cmd_set();
        cmd_wr(8'h84);
        wp_n = 1'b0;
        wait_clks(4);
        cmd_set();
        cmd_wr(8'h00);
        cmd_rd(s);
        chk("R6", "lock then pin low: refused", 32'(s), 32'h84);
        chk("R7", "latch cleared on refused write", 32'(s[1]), 0);
        wp_n = 1'b1;
        wait_clks(4);
        cmd_set();
        cmd_wr(8'h00);
        cmd_rd(s);
        chk("R6", "pin high releases", 32'(s), 32'h00);
    endtask

    task automatic t_hpm_pin_first();
        logic [7:0] s;
        wp_n = 1'b0;
        wait_clks(4);
        cmd_set();
        cmd_wr(8'h88);
        cmd_rd(s);
        chk("R4", "lock set with pin low", 32'(s), 32'h88);
        cmd_set();
        cmd_wr(8'h00);
        cmd_rd(s);
        chk("R6", "pin low then lock: refused", 32'(s), 32'h88);
        wp_n = 1'b1;
        wait_clks(4);
        cmd_set();
        cmd_wr(8'h00);
        cmd_rd(s);
        chk("R6", "release after pin-first entry", 32'(s), 32'h00);
    endtask

    task automatic t_framing();
        logic [7:0] s;
        logic [7:0] r;
        spi_txn({8'h06, 16'h0}, 9, r);
        cmd_rd(s);
        chk("R8", "06h plus one bit", 32'(s), 32'h00);
        spi_txn({8'h06, 16'h0}, 7, r);
        cmd_rd(s);
        chk("R8", "seven bits", 32'(s), 32'h00);
        spi_txn({8'h06, 8'h06, 8'h0}, 16, r);
        cmd_rd(s);
        chk("R8", "06h sent twice in one select", 32'(s), 32'h00);
        cmd_set();
        spi_txn({8'h01, 8'h10, 8'h00}, 24, r);
        cmd_rd(s);
        chk("R8", "three-byte write ignored, latch kept", 32'(s), 32'h02);
        spi_txn({8'h01, 8'h10, 8'h00}, 12, r);
        cmd_rd(s);
        chk("R8", "write cut mid-byte", 32'(s), 32'h02);
        cmd_clr();
    endtask

    task automatic t_mode3();
        logic [7:0] s;
        m3 = 1'b1;
        cmd_set();
        cmd_wr(8'h14);
        cmd_set();
        cmd_rd(s);
        chk("R9", "mode 3 write and read", 32'(s), 32'h16);
        cmd_clr();
        cmd_rd(s);
        chk("R9", "mode 3 latch clear", 32'(s), 32'h14);
        cmd_set();
        cmd_wr(8'h00);
        m3 = 1'b0;
    endtask

    task automatic t_busy_repeat();
        logic [7:0] s;
        cmd_set();
        busy_in = 1'b1;
        chk_addr = 17'h0;
        wait_clks(2);
        chk("R11", "busy blocks permission", 32'(addr_writable), 0);
        spi_txn({8'h05, 16'h0}, 24, s);
        chk("R3", "third byte repeats live status", 32'(s), 32'h03);
        busy_in = 1'b0;
        wait_clks(2);
        chk("R11", "idle restores permission", 32'(addr_writable), 1);
        cmd_clr();
    endtask

    task automatic t_miso_idle();
        logic [7:0] s;
        cmd_set();
        spi_txn({8'h06, 16'h0}, 8, s);
        chk("R12", "data out during non-read command", 32'(s), 32'h00);
        wait_clks(3);
        chk("R12", "data out with select high", 32'(spi_miso), 0);
        cmd_clr();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        wait_clks(5);
        rst = 1'b0;
        wait_clks(5);
        t_reset();
        t_latch();
        t_no_latch();
        t_write();
        t_regions();
        t_hpm_lock_first();
        t_hpm_pin_first();
        t_framing();
        t_mode3();
        t_busy_repeat();
        t_miso_idle();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule